// File: doc/BRIEF.md
# Slave-Mode Speed Auto-Detector

This block sits behind the serial audio port of a converter running as a clock follower. The left/right frame clock arrives from outside. The block counts master-clock cycles across each frame. From that count it decides the master-clock-to-frame ratio. It then picks the converter's speed class (single, double or quad) and whether the internal master-clock prescaler divides by two.

A ratio of 256 can belong to either single or double speed. A ratio of 128 can belong to either double or quad speed. To tell these apart, the block also counts strobes of a slow reference timebase in each frame. That count gives an inverse estimate of the sample rate. Few strobes per frame means a high rate.

A result is trusted only when two frames in a row agree. Illegal ratios raise an error flag. The block runs only when both mode pins are high. At any other mode setting it stays idle and reports nothing. It produces no clocks and moves no audio data.

Top module: `speed_autodetect`

## Requirements
- R1: While `rst_n` is low, `speed`, `prescale_div2`, `locked` and `unsupported` are all 0.
- R2: When `mode_pins` is anything other than 2'b11, `locked` and `unsupported` are 0 from the next cycle on, whatever `lrck_in` does.
- R3: `lrck_in` passes through a synchroniser of at least two flops. A frame length is the number of `mclk` cycles between two successive synchronised rising edges. A strobe count is the number of `ref_tick` pulses within that frame.
- R4: A frame of 256 cycles gives single speed (`speed`=2'b00) with `prescale_div2`=0 when the strobe count exceeds 14. With 14 strobes or fewer it gives double speed (`speed`=2'b01) with `prescale_div2`=1. These thresholds assume the default parameters.
- R5: A frame of 128 cycles gives double speed with `prescale_div2`=0 when the strobe count exceeds 7. With 7 strobes or fewer it gives quad speed (`speed`=2'b10) with `prescale_div2`=1.
- R6: A frame of 512 cycles gives single speed with `prescale_div2`=1 when the strobe count exceeds 14. Otherwise it is unsupported.
- R7: A frame of 64 cycles is unsupported: `unsupported`=1 and `locked`=0.
- R8: A frame within ±1 cycle of a nominal ratio is classified as that ratio.
- R9: A frame length that matches no ratio drives `unsupported` to 1 and `locked` to 0. `unsupported` returns to 0 at the first frame that classifies as valid.
- R10: More than 500 strobes in one frame (a rate below the lowest supported one) is unsupported, whatever the ratio.
- R11: `locked` rises only when two consecutive frames differ by at most one cycle and give the same class. Frames that alternate by two cycles never lock. `speed` and `prescale_div2` take the new class in the same cycle that `locked` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_pins | input | 2 | Mode selection; 2'b11 enables detection |
| lrck_in | input | 1 | External left/right frame clock, asynchronous |
| ref_tick | input | 1 | One-cycle strobe from the reference timebase |
| speed | output | 2 | Detected speed: 00 single, 01 double, 10 quad |
| prescale_div2 | output | 1 | 1 when the internal prescaler divides by two |
| locked | output | 1 | Two consecutive frames agreed on a legal class |
| unsupported | output | 1 | Last frame had an illegal ratio or rate |

## Verification
The bench goes after the ambiguous ratios from both sides of each rate split. A design that ignored the timebase would report single speed for a fast 256x frame, or double speed for a fast 128x frame.

It feeds frames one cycle off nominal. An exact-match decoder would flag these as unsupported.

It also feeds frames that alternate by two cycles. Here a tracker that compared only classes, not lengths, would claim lock.

It covers 64x frames, very slow frames, fast 512x frames and a mode change while locked. A design that kept stale lock or error state, or accepted the wrong ratio, would show the wrong flags at these points.

// File: rtl/speed_det_pkg.sv
package speed_det_pkg;

   typedef enum logic [1:0] {
      SPD_SINGLE = 2'b00,
      SPD_DOUBLE = 2'b01,
      SPD_QUAD   = 2'b10
   } speed_e;

   typedef struct packed {
      logic   ok;
      speed_e speed;
      logic   div2;
   } rate_cls_t;

   localparam logic [1:0] FOLLOWER_PINS = 2'b11;
   localparam int         N_RATIOS      = 4;

endpackage

// File: rtl/lrck_edge_sync.sv
module lrck_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lrck_async,
   output logic rise
);
   localparam int CHAIN = SYNC_STAGES + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("lrck_edge_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [CHAIN-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN-2:0], lrck_async};
   end

   assign rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];

   // R3
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/period_meter.sv
module period_meter #(
   parameter int CNT_W  = 11,
   parameter int TICK_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              rise,
   input  logic              ref_tick,
   output logic              meas_valid,
   output logic [CNT_W-1:0]  period,
   output logic [TICK_W-1:0] ticks
);
   localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [TICK_W-1:0] TICK_MAX = {TICK_W{1'b1}};

   logic              started;
   logic [CNT_W-1:0]  cyc_cnt;
   logic [TICK_W-1:0] tick_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         started    <= 1'b0;
         cyc_cnt    <= '0;
         tick_cnt   <= '0;
         meas_valid <= 1'b0;
         period     <= '0;
         ticks      <= '0;
      end else if (rise) begin
         started    <= 1'b1;
         meas_valid <= started;
         period     <= cyc_cnt;
         ticks      <= tick_cnt;
         cyc_cnt    <= CNT_W'(1);
         tick_cnt   <= TICK_W'(ref_tick);
      end else begin
         meas_valid <= 1'b0;
         if (cyc_cnt != CNT_MAX) cyc_cnt <= cyc_cnt + 1'b1;
         if (ref_tick && tick_cnt != TICK_MAX) tick_cnt <= tick_cnt + 1'b1;
      end
   end

   // R3
   meas_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |=> !meas_valid);

   // R3
   nonzero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |-> (period != '0));

endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier
   import speed_det_pkg::*;
#(
   parameter int CNT_W      = 11,
   parameter int TICK_W     = 10,
   parameter int BASE_RATIO = 64,
   parameter int TOL        = 1,
   parameter int SPLIT_LO_T = 14,
   parameter int SPLIT_HI_T = 7,
   parameter int SLOW_T     = 500
) (
   input  logic [CNT_W-1:0]  period,
   input  logic [TICK_W-1:0] ticks,
   output rate_cls_t         cls
);
   localparam logic [TICK_W-1:0] LO_T   = TICK_W'(SPLIT_LO_T);
   localparam logic [TICK_W-1:0] HI_T   = TICK_W'(SPLIT_HI_T);
   localparam logic [TICK_W-1:0] SLOW_L = TICK_W'(SLOW_T);

   generate
      if (2 * TOL >= BASE_RATIO) begin : g_bad_tol
         $error("ratio_classifier: TOL too wide for BASE_RATIO");
      end
      if (SPLIT_HI_T >= SPLIT_LO_T) begin : g_bad_split
         $error("ratio_classifier: split thresholds out of order");
      end
   endgenerate

   // hit[0]=x1 base, hit[1]=x2, hit[2]=x4, hit[3]=x8
   logic [N_RATIOS-1:0] hit;

   generate
      for (genvar g = 0; g < N_RATIOS; g++) begin : g_ratio
         localparam logic [CNT_W-1:0] LOW_B  = CNT_W'((BASE_RATIO << g) - TOL);
         localparam logic [CNT_W-1:0] HIGH_B = CNT_W'((BASE_RATIO << g) + TOL);
         assign hit[g] = (period >= LOW_B) && (period <= HIGH_B);
      end
   endgenerate

   logic fast_lo, fast_hi, too_slow;
   assign fast_lo  = (ticks <= LO_T);
   assign fast_hi  = (ticks <= HI_T);
   assign too_slow = (ticks > SLOW_L);

   always_comb begin
      cls = '{ok: 1'b0, speed: SPD_SINGLE, div2: 1'b0};
      if (!too_slow) begin
         if (hit[3]) begin
            cls = '{ok: !fast_lo, speed: SPD_SINGLE, div2: 1'b1};
         end else if (hit[2]) begin
            cls = fast_lo ? '{ok: 1'b1, speed: SPD_DOUBLE, div2: 1'b1}
                          : '{ok: 1'b1, speed: SPD_SINGLE, div2: 1'b0};
         end else if (hit[1]) begin
            cls = fast_hi ? '{ok: 1'b1, speed: SPD_QUAD,   div2: 1'b1}
                          : '{ok: 1'b1, speed: SPD_DOUBLE, div2: 1'b0};
         end
      end
   end

endmodule

// File: rtl/lock_tracker.sv
module lock_tracker
   import speed_det_pkg::*;
#(
   parameter int CNT_W = 11,
   parameter int TOL   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             meas_valid,
   input  logic [CNT_W-1:0] period,
   input  rate_cls_t        cls,
   output logic [1:0]       speed,
   output logic             prescale_div2,
   output logic             locked,
   output logic             unsupported
);
   localparam logic [CNT_W-1:0] TOL_C = CNT_W'(TOL);

   logic             prev_ok;
   logic [CNT_W-1:0] prev_period;
   rate_cls_t        prev_cls;
   logic [CNT_W-1:0] gap;
   logic             agree;

   assign gap   = (period >= prev_period) ? (period - prev_period)
                                          : (prev_period - period);
   assign agree = prev_ok && (gap <= TOL_C) && (cls == prev_cls);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_ok       <= 1'b0;
         prev_period   <= '0;
         prev_cls      <= '0;
         speed         <= SPD_SINGLE;
         prescale_div2 <= 1'b0;
         locked        <= 1'b0;
         unsupported   <= 1'b0;
      end else if (!active) begin
         prev_ok     <= 1'b0;
         locked      <= 1'b0;
         unsupported <= 1'b0;
      end else if (meas_valid) begin
         if (!cls.ok) begin
            prev_ok     <= 1'b0;
            locked      <= 1'b0;
            unsupported <= 1'b1;
         end else begin
            unsupported <= 1'b0;
            prev_ok     <= 1'b1;
            prev_period <= period;
            prev_cls    <= cls;
            locked      <= agree;
            if (agree) begin
               speed         <= cls.speed;
               prescale_div2 <= cls.div2;
            end
         end
      end
   end

   // R9
   lock_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(locked && unsupported));

   // R11
   lock_on_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(meas_valid));

   // R4
   legal_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (speed != 2'b11));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (!locked && !unsupported));

endmodule

// File: rtl/speed_autodetect.sv
module speed_autodetect
   import speed_det_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int BASE_RATIO   = 64,
   parameter int TOL          = 1,
   parameter int REF_KHZ      = 1000,
   parameter int MIN_KHZ      = 2,
   parameter int SPLIT_LO_KHZ = 68,
   parameter int SPLIT_HI_KHZ = 136
) (
   input  logic       mclk,
   input  logic       rst_n,
   input  logic [1:0] mode_pins,
   input  logic       lrck_in,
   input  logic       ref_tick,
   output logic [1:0] speed,
   output logic       prescale_div2,
   output logic       locked,
   output logic       unsupported
);
   localparam int MAX_RATIO  = BASE_RATIO << (N_RATIOS - 1);
   localparam int SPLIT_LO_T = REF_KHZ / SPLIT_LO_KHZ;
   localparam int SPLIT_HI_T = REF_KHZ / SPLIT_HI_KHZ;
   localparam int SLOW_T     = REF_KHZ / MIN_KHZ;
   localparam int CNT_W      = $clog2(MAX_RATIO + TOL + 1) + 1;
   localparam int TICK_W     = $clog2(SLOW_T + 2) + 1;

   generate
      if (SPLIT_HI_KHZ <= SPLIT_LO_KHZ || MIN_KHZ <= 0) begin : g_bad_rates
         $error("speed_autodetect: rate parameters inconsistent");
      end
   endgenerate

   logic             active;
   logic             rise;
   logic             meas_valid;
   logic [CNT_W-1:0] period;
   logic [TICK_W-1:0] ticks;
   rate_cls_t        cls;

   assign active = (mode_pins == FOLLOWER_PINS);

   lrck_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(mclk), .rst_n(rst_n), .lrck_async(lrck_in), .rise(rise));

   period_meter #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_meter (
      .clk(mclk), .rst_n(rst_n), .run(active), .rise(rise),
      .ref_tick(ref_tick), .meas_valid(meas_valid),
      .period(period), .ticks(ticks));

   ratio_classifier #(
      .CNT_W(CNT_W), .TICK_W(TICK_W), .BASE_RATIO(BASE_RATIO), .TOL(TOL),
      .SPLIT_LO_T(SPLIT_LO_T), .SPLIT_HI_T(SPLIT_HI_T), .SLOW_T(SLOW_T)
   ) u_class (
      .period(period), .ticks(ticks), .cls(cls));

   lock_tracker #(.CNT_W(CNT_W), .TOL(TOL)) u_lock (
      .clk(mclk), .rst_n(rst_n), .active(active), .meas_valid(meas_valid),
      .period(period), .cls(cls), .speed(speed),
      .prescale_div2(prescale_div2), .locked(locked),
      .unsupported(unsupported));

endmodule

// File: tb/speed_autodetect_test.sv
module speed_autodetect_test;

   typedef struct packed {
      int         ratio;
      int         tick_per;
      logic [1:0] spd;
      logic       div2;
      logic       lk;
      logic       er;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{256,  8, 2'b00, 1'b0, 1'b1, 1'b0},   // R4 slow 256x -> single
      '{256, 24, 2'b01, 1'b1, 1'b1, 1'b0},   // R4 fast 256x -> double
      '{128,  8, 2'b01, 1'b0, 1'b1, 1'b0},   // R5 slow 128x -> double
      '{128, 24, 2'b10, 1'b1, 1'b1, 1'b0},   // R5 fast 128x -> quad
      '{512,  8, 2'b00, 1'b1, 1'b1, 1'b0},   // R6 512x -> single div2
      '{512, 48, 2'b00, 1'b0, 1'b0, 1'b1},   // R6 fast 512x unsupported
      '{ 64,  2, 2'b00, 1'b0, 1'b0, 1'b1},   // R7 64x unsupported
      '{300,  8, 2'b00, 1'b0, 1'b0, 1'b1},   // R9 no ratio
      '{512,  1, 2'b00, 1'b0, 1'b0, 1'b1},   // R10 too slow
      '{257,  8, 2'b00, 1'b0, 1'b1, 1'b0},   // R8 +1, R9 error clears
      '{127, 24, 2'b10, 1'b1, 1'b1, 1'b0}    // R8 -1 quad
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_pins = 2'b11;
   logic       lrck_in = 1'b0;
   logic       ref_tick = 1'b0;
   logic [1:0] speed;
   logic       prescale_div2;
   logic       locked;
   logic       unsupported;

   int  tests_run = 0;
   int  tests_failed = 0;
   bit  finished = 1'b0;

   int  cur_ratio = 0;
   int  cur_per = 0;
   bit  cur_alt = 1'b0;

   speed_autodetect uut (
      .mclk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .lrck_in(lrck_in),
      .ref_tick(ref_tick), .speed(speed), .prescale_div2(prescale_div2),
      .locked(locked), .unsupported(unsupported));

   always #10 clk = ~clk;

   // frame clock generator
   int  lc = 0;
   int  plen = 0;
   bit  phase = 1'b0;
   always @(negedge clk) begin
      if (cur_ratio == 0) begin
         lrck_in = 1'b0;
         lc = 0;
         plen = 0;
      end else begin
         if (lc >= plen - 1) begin
            lc = 0;
            phase = ~phase;
            plen = cur_alt ? (phase ? cur_ratio + 1 : cur_ratio - 1) : cur_ratio;
         end else begin
            lc = lc + 1;
         end
         lrck_in = (lc < plen / 2);
      end
   end

   // reference strobe generator
   int rc = 0;
   always @(negedge clk) begin
      if (cur_per == 0) begin
         ref_tick = 1'b0;
         rc = 0;
      end else begin
         ref_tick = (rc == 0);
         rc = (rc >= cur_per - 1) ? 0 : rc + 1;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      tests_run++;
      if (act != exp) begin
         tests_failed++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      cycles(5);
      // R1: reset state
      chk("R1 speed", speed, 0);
      chk("R1 div2", prescale_div2, 0);
      chk("R1 locked", locked, 0);
      chk("R1 unsupported", unsupported, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         cur_ratio = VECS[i].ratio;
         cur_per   = VECS[i].tick_per;
         cycles(7 * VECS[i].ratio + 20);
         chk($sformatf("vec%0d locked (R4-R10 table)", i), locked, VECS[i].lk);
         chk($sformatf("vec%0d unsupported", i), unsupported, VECS[i].er);
         if (VECS[i].lk) begin
            chk($sformatf("vec%0d speed", i), speed, VECS[i].spd);
            chk($sformatf("vec%0d div2", i), prescale_div2, VECS[i].div2);
         end
      end

      // R11: frames alternating by two cycles never lock
      cur_ratio = 256; cur_per = 8; cur_alt = 1'b1;
      cycles(10 * 256);
      chk("R11 alternating locked", locked, 0);
      chk("R8 alternating unsupported", unsupported, 0);

      // R11: steady frames lock with the right class
      cur_alt = 1'b0;
      cycles(7 * 256);
      chk("R11 steady locked", locked, 1);
      chk("R11 steady speed", speed, 0);

      // R2: leaving follower mode clears flags
      mode_pins = 2'b01;
      cycles(3);
      chk("R2 locked idle", locked, 0);
      chk("R2 unsupported idle", unsupported, 0);
      cur_ratio = 300;
      cycles(6 * 300);
      chk("R2 bad ratio ignored", unsupported, 0);

      // back to follower mode, quad rate
      mode_pins = 2'b11;
      cur_ratio = 128; cur_per = 24;
      cycles(7 * 128 + 20);
      chk("R5 relock", locked, 1);
      chk("R5 relock speed", speed, 2);

      // R1: reset while locked
      rst_n = 1'b0;
      cycles(3);
      chk("R1 mid locked", locked, 0);
      chk("R1 mid speed", speed, 0);
      chk("R1 mid div2", prescale_div2, 0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         tests_run++;
         tests_failed++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
         $finish;
      end
   end

endmodule